// File: doc/BRIEF.md
# HDLC Receiver with Address Filter

This block takes a serial HDLC line, one bit per strobe of a bit-clock enable, and turns it into bytes in a small output queue. It looks for the opening flag and removes the zeros inserted after runs of five ones. It recognises closing flags and abort sequences and checks the 16-bit frame check sequence over each frame. The two check bytes are removed. Every stored byte carries a last-byte marker and a two-bit status. On the final byte of a frame the status tells a clean end from a check failure or an abort. Frames that are too short leave nothing behind.

When address filtering is on, a frame is kept only if its first byte matches the programmed station address in its upper bits or equals the broadcast value. The receive enable starts the search for flags at once. Dropping the enable lets a frame already in progress run to its end. A transparent setting bypasses all framing and packs raw bits into bytes. Those bytes are aligned to the restart of the enable. A consumer drains the queue with a pop strobe and sees each entry one cycle later.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After reset the queue is empty: `out_avail` and `out_valid` are 0.
- R2: Bytes are assembled least significant bit first. For a frame with a correct check sequence, all bytes between the flags except the last two are stored in order. Only the final stored byte has `out_last`=1, and every stored byte has `out_status`=00.
- R3: A 0 that follows five consecutive 1s inside a frame is removed before byte assembly, so data holding flag-like patterns and long runs of ones comes out unchanged.
- R4: The check is CRC-16 with reflected polynomial 0x8408 and start value 0xFFFF, run over every byte including the two check bytes. If the remainder at the closing flag is not 0xF0B8, or the frame did not end on a byte boundary, the final stored byte gets status 01.
- R5: Seven or more consecutive 1s abort a frame. If at least four bytes of the frame had been received, the last data byte held back is stored with `out_last`=1 and status 10. Otherwise nothing of that frame is stored.
- R6: A frame with fewer than four bytes between its flags, check bytes included, stores nothing.
- R7: With `addr_filter_en`=1, a frame is kept only when its first byte equals 0xFF or matches `station_addr` in bits 7..2. All other frames are dropped entirely. With `addr_filter_en`=0, every frame is kept.
- R8: A single flag may both close one frame and open the next, and both frames are stored.
- R9: While `rx_enable` is low and no frame is in progress, nothing is stored. When `rx_enable` rises, the receiver starts hunting for a flag.
- R10: If `rx_enable` falls after a frame's first byte has arrived, that frame is still received and stored in full. Nothing after it is stored until `rx_enable` rises again.
- R11: In transparent mode (`transparent`=1 when `rx_enable` rises), every 8 received bits form one stored byte with `out_last`=0 and status 00. No zero deletion and no flag, abort or check handling takes place.
- R12: In transparent mode, a low period of `rx_enable` discards any partial byte. Byte alignment restarts at the first bit after `rx_enable` returns high.
- R13: A pop while `out_avail`=1 yields the oldest entry with `out_valid`=1 on the next cycle. A pop while empty yields `out_valid`=0. The queue never holds more than its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe marking a valid line bit |
| rx_bit | input | 1 | Serial line data |
| rx_enable | input | 1 | Receive enable |
| addr_filter_en | input | 1 | Turns on first-byte address filtering |
| station_addr | input | 8 | Programmed station address |
| transparent | input | 1 | Raw bit packing without framing, taken when enable rises |
| out_pop | input | 1 | Removes the oldest queue entry |
| out_avail | output | 1 | Queue holds at least one entry |
| out_valid | output | 1 | Popped entry is presented this cycle |
| out_data | output | 8 | Popped byte |
| out_last | output | 1 | Popped byte ends its frame |
| out_status | output | 2 | 00 clean, 01 check failure, 10 abort |

## Verification
Frames are sent with plain bytes, then with bytes full of ones and flag images, so zero deletion is exercised apart from byte assembly. A corrupted check field is used to tell status 01 from a clean end. Aborts are sent after two and after four bytes, and frames are sent at three and four bytes long, so each threshold is probed from both sides. Address filtering is tried with a partial-bit match, a mismatch in the compared bits and the broadcast value. Shared flags, an enable dropped mid-frame and transparent bytes that look like flags and aborts show whether framing state is carried, ended or bypassed. Transparent mode is also sent a stray partial byte to show that alignment restarts with the enable.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_HUNT  = 3'd1,
    M_FRAME = 3'd2,
    M_SKIP  = 3'd3,
    M_XPAR  = 3'd4
  } rx_mode_e;

  localparam logic [1:0] ST_GOOD  = 2'b00;
  localparam logic [1:0] ST_FCS   = 2'b01;
  localparam logic [1:0] ST_ABORT = 2'b10;

  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RV = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [7:0]  BROADCAST   = 8'hFF;

  typedef struct packed {
    logic [1:0] status;
    logic       last;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_RV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
`timescale 1ns/1ps
module hdlc_rx_bitproc #(
  parameter int RUN_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic xpar,
  input  logic bit_en,
  input  logic rx_bit,
  output logic d_valid,
  output logic d_bit,
  output logic flag_det,
  output logic abort_det
);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(7);

  logic [RUN_W-1:0] ones_q, ones_n;

  always_comb begin
    ones_n    = ones_q;
    d_valid   = 1'b0;
    d_bit     = 1'b0;
    flag_det  = 1'b0;
    abort_det = 1'b0;
    if (!active) begin
      ones_n = '0;
    end else if (bit_en) begin
      if (xpar) begin
        d_valid = 1'b1;
        d_bit   = rx_bit;
        ones_n  = '0;
      end else if (rx_bit) begin
        ones_n = (ones_q == RUN_MAX) ? RUN_MAX : ones_q + 1'b1;
        if (ones_q == RUN_FLAG) abort_det = 1'b1;
        if (ones_q < RUN_STUFF) begin
          d_valid = 1'b1;
          d_bit   = 1'b1;
        end
      end else begin
        ones_n = '0;
        if (ones_q == RUN_FLAG) begin
          flag_det = 1'b1;
        end else if (ones_q < RUN_STUFF) begin
          d_valid = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ones_q <= '0;
    else     ones_q <= ones_n;
  end

endmodule

// File: rtl/hdlc_rx_framer.sv
`timescale 1ns/1ps
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int ADDR_MSBS = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_enable,
  input  logic       xpar_req,
  input  logic       addr_en,
  input  logic [7:0] station_addr,
  input  logic       d_valid,
  input  logic       d_bit,
  input  logic       flag_det,
  input  logic       abort_det,
  output rx_mode_e   mode,
  output logic       wr_en,
  output rx_entry_t  wr_entry
);
  localparam logic [7:0] ADDR_MASK = 8'(8'hFF << (8 - ADDR_MSBS));
  localparam logic [2:0] CNT_PEND  = 3'd3;
  localparam logic [2:0] CNT_MIN   = 3'd4;
  localparam logic [2:0] BIT_LAST  = 3'd7;
  localparam logic [2:0] BIT_FLAGD = 3'd6;

  rx_mode_e    mode_q, mode_n;
  logic [6:0]  sreg_q, sreg_n;
  logic [2:0]  bitcnt_q, bitcnt_n;
  logic [2:0]  bytecnt_q, bytecnt_n;
  logic [15:0] crc_q, crc_n;
  logic [7:0]  hold0_q, hold0_n, hold1_q, hold1_n, pend_q, pend_n;
  logic        wr_n;
  rx_entry_t   ent_n;

  logic [7:0] new_byte;
  logic       byte_done, addr_ok, restart;

  assign new_byte  = {d_bit, sreg_q};
  assign byte_done = d_valid && (bitcnt_q == BIT_LAST);
  assign addr_ok   = !addr_en || (new_byte == BROADCAST) ||
                     (((new_byte ^ station_addr) & ADDR_MASK) == 8'h00);

  always_comb begin
    mode_n    = mode_q;
    sreg_n    = sreg_q;
    bitcnt_n  = bitcnt_q;
    bytecnt_n = bytecnt_q;
    crc_n     = crc_q;
    hold0_n   = hold0_q;
    hold1_n   = hold1_q;
    pend_n    = pend_q;
    wr_n      = 1'b0;
    ent_n     = '{status: ST_GOOD, last: 1'b0, data: pend_q};
    restart   = 1'b0;

    unique case (mode_q)
      M_IDLE: begin
        if (rx_enable) begin
          mode_n    = xpar_req ? M_XPAR : M_HUNT;
          bitcnt_n  = '0;
          bytecnt_n = '0;
        end
      end
      M_HUNT: begin
        if (flag_det) restart = 1'b1;
      end
      M_FRAME: begin
        if (flag_det) begin
          if (bytecnt_q >= CNT_MIN) begin
            wr_n       = 1'b1;
            ent_n.last = 1'b1;
            ent_n.status = ((bitcnt_q == BIT_FLAGD) && (crc_q == CRC_RESIDUE)) ? ST_GOOD : ST_FCS;
          end
          restart = 1'b1;
        end else if (abort_det) begin
          if (bytecnt_q >= CNT_MIN) begin
            wr_n         = 1'b1;
            ent_n.last   = 1'b1;
            ent_n.status = ST_ABORT;
          end
          mode_n = M_HUNT;
        end else if (d_valid) begin
          sreg_n   = {d_bit, sreg_q[6:1]};
          bitcnt_n = bitcnt_q + 1'b1;
          if (byte_done) begin
            crc_n     = crc16_byte(crc_q, new_byte);
            bytecnt_n = (bytecnt_q >= CNT_MIN) ? CNT_MIN : bytecnt_q + 1'b1;
            pend_n    = hold1_q;
            hold1_n   = hold0_q;
            hold0_n   = new_byte;
            if (bytecnt_q >= CNT_PEND) wr_n = 1'b1;
            if ((bytecnt_q == 3'd0) && !addr_ok) mode_n = M_SKIP;
          end
        end
      end
      M_SKIP: begin
        if (flag_det)       restart = 1'b1;
        else if (abort_det) mode_n  = M_HUNT;
      end
      M_XPAR: begin
        if (d_valid) begin
          sreg_n   = {d_bit, sreg_q[6:1]};
          bitcnt_n = bitcnt_q + 1'b1;
          if (byte_done) begin
            wr_n       = 1'b1;
            ent_n.data = new_byte;
          end
        end
      end
      default: mode_n = M_IDLE;
    endcase

    if (restart) begin
      mode_n    = M_FRAME;
      bitcnt_n  = '0;
      bytecnt_n = '0;
      crc_n     = CRC_INIT;
    end

    if (!rx_enable && (mode_n != M_IDLE) &&
        !((mode_n == M_FRAME) && (bytecnt_n != 3'd0))) begin
      mode_n = M_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_IDLE;
      sreg_q    <= '0;
      bitcnt_q  <= '0;
      bytecnt_q <= '0;
      crc_q     <= CRC_INIT;
      hold0_q   <= '0;
      hold1_q   <= '0;
      pend_q    <= '0;
      wr_en     <= 1'b0;
      wr_entry  <= '0;
    end else begin
      mode_q    <= mode_n;
      sreg_q    <= sreg_n;
      bitcnt_q  <= bitcnt_n;
      bytecnt_q <= bytecnt_n;
      crc_q     <= crc_n;
      hold0_q   <= hold0_n;
      hold1_q   <= hold1_n;
      pend_q    <= pend_n;
      wr_en     <= wr_n;
      wr_entry  <= ent_n;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/hdlc_rx_fifo.sv
`timescale 1ns/1ps
module hdlc_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic [AW:0]      level
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic             do_wr, do_rd;

  assign do_wr = wr_en && (level != FULL);
  assign do_rd = rd_en && (level != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
    if (do_rd) rd_data <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/hdlc_rx_filter.sv
`timescale 1ns/1ps
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_MSBS  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       rx_enable,
  input  logic       addr_filter_en,
  input  logic [7:0] station_addr,
  input  logic       transparent,
  input  logic       out_pop,
  output logic       out_avail,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic [1:0] out_status
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  rx_mode_e   fr_mode;
  logic       fr_wr_en;
  rx_entry_t  fr_entry;
  logic       bp_valid, bp_bit, bp_flag, bp_abort;
  logic [LVL_W-1:0] fifo_level;
  logic [ENTRY_W-1:0] rd_word;
  rx_entry_t  rd_entry;

  hdlc_rx_bitproc u_bits (
    .clk       (clk),
    .rst       (rst),
    .active    (fr_mode != M_IDLE),
    .xpar      (fr_mode == M_XPAR),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .d_valid   (bp_valid),
    .d_bit     (bp_bit),
    .flag_det  (bp_flag),
    .abort_det (bp_abort)
  );

  hdlc_rx_framer #(.ADDR_MSBS(ADDR_MSBS)) u_frm (
    .clk          (clk),
    .rst          (rst),
    .rx_enable    (rx_enable),
    .xpar_req     (transparent),
    .addr_en      (addr_filter_en),
    .station_addr (station_addr),
    .d_valid      (bp_valid),
    .d_bit        (bp_bit),
    .flag_det     (bp_flag),
    .abort_det    (bp_abort),
    .mode         (fr_mode),
    .wr_en        (fr_wr_en),
    .wr_entry     (fr_entry)
  );

  hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_q (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fr_wr_en),
    .wr_data  (fr_entry),
    .rd_en    (out_pop),
    .rd_valid (out_valid),
    .rd_data  (rd_word),
    .level    (fifo_level)
  );

  assign rd_entry   = rd_word;
  assign out_avail  = (fifo_level != '0);
  assign out_data   = rd_entry.data;
  assign out_last   = rd_entry.last;
  assign out_status = rd_entry.status;

endmodule

// File: rtl/hdlc_rx_checker.sv
`timescale 1ns/1ps
module hdlc_rx_checker
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         mode,
  input logic               wr_en,
  input logic [ENTRY_W-1:0] wr_word,
  input logic               out_pop,
  input logic               out_avail,
  input logic               out_valid,
  input logic               out_last,
  input logic [1:0]         out_status,
  input logic [LW-1:0]      level
);
  rx_entry_t wr_e;
  assign wr_e = wr_word;

  // R9: a receiver that stays stopped produces no queue writes
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'(M_IDLE) && $past(mode) == 3'(M_IDLE)) |-> !wr_en);

  // R11: raw-packed bytes are never frame ends and never flagged
  p_xpar_plain_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 3'(M_XPAR)) |-> (wr_e.status == ST_GOOD && !wr_e.last));

  // R2: bytes inside a frame carry a clean status
  p_mid_status_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_status == ST_GOOD));

  // R4: only the three defined status codes appear
  p_status_code_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_status != 2'b11));

  // R13: pop behaviour
  p_pop_data_r13: assert property (@(posedge clk) disable iff (rst)
    (out_pop && out_avail) |=> out_valid);
  p_pop_empty_r13: assert property (@(posedge clk) disable iff (rst)
    (out_pop && !out_avail) |=> !out_valid);
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

endmodule

bind hdlc_rx_filter hdlc_rx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (fr_mode),
  .wr_en      (fr_wr_en),
  .wr_word    (fr_entry),
  .out_pop    (out_pop),
  .out_avail  (out_avail),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_status (out_status),
  .level      (fifo_level)
);

// File: tb/sim_hdlc_rx_filter.sv
`timescale 1ns/1ps
module sim_hdlc_rx_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, rx_bit = 1'b1, rx_enable = 1'b0;
  logic       addr_filter_en = 1'b0, transparent = 1'b0, out_pop = 1'b0;
  logic [7:0] station_addr = 8'h00;
  logic       out_avail, out_valid, out_last;
  logic [7:0] out_data;
  logic [1:0] out_status;

  int nerr = 0;
  int nchk = 0;
  int tx_ones = 0;
  logic [15:0] tx_crc = 16'hFFFF;

  always #2.5 clk = ~clk;

  hdlc_rx_filter u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .rx_enable(rx_enable),
    .addr_filter_en(addr_filter_en), .station_addr(station_addr), .transparent(transparent),
    .out_pop(out_pop), .out_avail(out_avail), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_status(out_status)
  );

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_flag();
    send_raw(8'h7E);
    tx_ones = 0;
    tx_crc  = 16'hFFFF;
  endtask

  task automatic send_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      tx_ones = b[i] ? tx_ones + 1 : 0;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end
  endtask

  task automatic send_data(input logic [7:0] b);
    tx_crc = ref_crc(tx_crc, b);
    send_stuffed(b);
  endtask

  task automatic send_fcs(input logic corrupt);
    logic [15:0] f = ~tx_crc;
    if (corrupt) f = f ^ 16'h0004;
    send_stuffed(f[7:0]);
    send_stuffed(f[15:8]);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic l, input logic [1:0] s, input string req);
    chk(out_avail == 1'b1, req, "avail before pop", int'(out_avail), 1);
    @(negedge clk); out_pop = 1'b1;
    @(negedge clk); out_pop = 1'b0;
    chk(out_valid == 1'b1, req, "valid", int'(out_valid), 1);
    chk(out_data == d, req, "data", int'(out_data), int'(d));
    chk({out_last, out_status} == {l, s}, req, "last/status", int'({out_last, out_status}), int'({l, s}));
  endtask

  task automatic expect_empty(input string req);
    repeat (4) @(negedge clk);
    chk(out_avail == 1'b0, req, "queue empty", int'(out_avail), 0);
  endtask

  task automatic t_reset();
    chk(out_avail == 1'b0, "R1", "avail after reset", int'(out_avail), 0);
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    @(negedge clk); out_pop = 1'b1;
    @(negedge clk); out_pop = 1'b0;
    chk(out_valid == 1'b0, "R13", "pop on empty", int'(out_valid), 0);
  endtask

  task automatic t_disabled();
    send_flag(); send_data(8'h12); send_data(8'h34); send_fcs(1'b0); send_flag();
    expect_empty("R9");
    rx_enable = 1'b1;
    repeat (3) @(negedge clk);
    send_flag(); send_data(8'h12); send_data(8'h34); send_data(8'h56); send_fcs(1'b0); send_flag();
    pop_expect(8'h12, 1'b0, 2'b00, "R2");
    pop_expect(8'h34, 1'b0, 2'b00, "R2");
    pop_expect(8'h56, 1'b1, 2'b00, "R2");
    expect_empty("R2");
  endtask

  task automatic t_stuff();
    send_flag();
    send_data(8'hFF); send_data(8'h7E); send_data(8'h3F); send_data(8'hF8); send_data(8'h01);
    send_fcs(1'b0); send_flag();
    pop_expect(8'hFF, 1'b0, 2'b00, "R3");
    pop_expect(8'h7E, 1'b0, 2'b00, "R3");
    pop_expect(8'h3F, 1'b0, 2'b00, "R3");
    pop_expect(8'hF8, 1'b0, 2'b00, "R3");
    pop_expect(8'h01, 1'b1, 2'b00, "R3");
    expect_empty("R3");
  endtask

  task automatic t_fcs();
    send_flag(); send_data(8'hA1); send_data(8'hB2); send_data(8'hC3); send_fcs(1'b1); send_flag();
    pop_expect(8'hA1, 1'b0, 2'b00, "R4");
    pop_expect(8'hB2, 1'b0, 2'b00, "R4");
    pop_expect(8'hC3, 1'b1, 2'b01, "R4");
    expect_empty("R4");
  endtask

  task automatic t_abort();
    send_flag(); send_data(8'hAA); send_data(8'hBB); send_data(8'hCC); send_data(8'hDD);
    send_raw(8'hFF);
    pop_expect(8'hAA, 1'b0, 2'b00, "R5");
    pop_expect(8'hBB, 1'b1, 2'b10, "R5");
    expect_empty("R5");
    send_flag(); send_data(8'h11); send_data(8'h22);
    send_raw(8'hFF);
    expect_empty("R5");
  endtask

  task automatic t_short();
    send_flag(); send_data(8'h55); send_fcs(1'b0); send_flag();
    expect_empty("R6");
    send_flag(); send_data(8'h55); send_data(8'h66); send_fcs(1'b0); send_flag();
    pop_expect(8'h55, 1'b0, 2'b00, "R6");
    pop_expect(8'h66, 1'b1, 2'b00, "R6");
    expect_empty("R6");
  endtask

  task automatic t_addr();
    addr_filter_en = 1'b1;
    station_addr   = 8'h40;
    send_flag(); send_data(8'h43); send_data(8'h01); send_fcs(1'b0); send_flag();
    send_flag(); send_data(8'h44); send_data(8'h02); send_fcs(1'b0); send_flag();
    send_flag(); send_data(8'hFF); send_data(8'h03); send_fcs(1'b0); send_flag();
    addr_filter_en = 1'b0;
    send_flag(); send_data(8'h44); send_data(8'h04); send_fcs(1'b0); send_flag();
    pop_expect(8'h43, 1'b0, 2'b00, "R7");
    pop_expect(8'h01, 1'b1, 2'b00, "R7");
    pop_expect(8'hFF, 1'b0, 2'b00, "R7");
    pop_expect(8'h03, 1'b1, 2'b00, "R7");
    pop_expect(8'h44, 1'b0, 2'b00, "R7");
    pop_expect(8'h04, 1'b1, 2'b00, "R7");
    expect_empty("R7");
  endtask

  task automatic t_shared();
    send_flag(); send_data(8'h10); send_data(8'h20); send_fcs(1'b0);
    send_flag(); send_data(8'h30); send_data(8'h40); send_fcs(1'b0);
    send_flag();
    pop_expect(8'h10, 1'b0, 2'b00, "R8");
    pop_expect(8'h20, 1'b1, 2'b00, "R8");
    pop_expect(8'h30, 1'b0, 2'b00, "R8");
    pop_expect(8'h40, 1'b1, 2'b00, "R8");
    expect_empty("R8");
  endtask

  task automatic t_graceful();
    send_flag(); send_data(8'h61); send_data(8'h62);
    rx_enable = 1'b0;
    send_data(8'h63); send_fcs(1'b0); send_flag();
    pop_expect(8'h61, 1'b0, 2'b00, "R10");
    pop_expect(8'h62, 1'b0, 2'b00, "R10");
    pop_expect(8'h63, 1'b1, 2'b00, "R10");
    send_flag(); send_data(8'h71); send_data(8'h72); send_fcs(1'b0); send_flag();
    expect_empty("R10");
  endtask

  task automatic t_xpar();
    transparent = 1'b1;
    rx_enable   = 1'b1;
    repeat (3) @(negedge clk);
    send_raw(8'h7E); send_raw(8'hFF); send_raw(8'h00);
    pop_expect(8'h7E, 1'b0, 2'b00, "R11");
    pop_expect(8'hFF, 1'b0, 2'b00, "R11");
    pop_expect(8'h00, 1'b0, 2'b00, "R11");
    expect_empty("R11");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    rx_enable = 1'b0;
    repeat (3) @(negedge clk);
    rx_enable = 1'b1;
    repeat (3) @(negedge clk);
    send_raw(8'hA5);
    pop_expect(8'hA5, 1'b0, 2'b00, "R12");
    expect_empty("R12");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_stuff();
    t_fcs();
    t_abort();
    t_short();
    t_addr();
    t_shared();
    t_graceful();
    t_xpar();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule